// File: doc/BRIEF.md
# Free-Running Timer with Output Compare and Input Capture

This block is a 16-bit up-counter behind a byte-wide register port. The counter runs without stopping from reset. A 2-bit prescale field sets how often it advances. Several compare channels watch the counter. When a channel's value is reached, the channel raises its flag and applies a 2-bit action code to its own output pin. Channel 0 is the master: on its match it loads any group of pins from a mask and data pair. Dedicated capture channels store the counter value when their input shows a chosen edge. The last compare channel can be switched into a further capture channel. A force register lets software fire a channel's pin action at once.

Software reads the count high byte first and then the low byte to get a coherent 16-bit value. It clears flags by writing ones to them. Each flag ANDed with its enable bit drives a separate request line. Priority and vector selection are left to the interrupt controller that receives these lines.

Top module: `tmr_core`

## Requirements
- R1: After reset the counter, every output pin, every flag and every request line is 0.
- R2: CTRL (0x02) bits [1:0] set the count period: 00 advances every clock, 01 every 4 clocks, 10 every 8 clocks, 11 every 16 clocks.
- R3: Reading CNT_HI (0x00) saves the counter's low byte. A CNT_LO (0x01) read in the next cycle returns the saved byte. A CNT_LO read at any other time returns the live low byte.
- R4: Channel k (k = 1..4) has a 2-bit action code at ACT (0x06) bits [2k-1:2k-2]. On its event, 00 leaves pin k alone, 01 inverts it, 10 drives it to 0 and 11 drives it to 1.
- R5: CMPk is written as high byte at 0x10+2k and low byte at 0x11+2k. In the cycle the counter takes the value CMPk, FLAG1 (0x07) bit k becomes 1 and the action of channel k is applied.
- R6: On a match of channel 0, every pin p whose MMASK (0x04) bit p is 1 takes MDATA (0x05) bit p. Unmasked pins are untouched.
- R7: If channel 0 and a channel's own action act on the same pin in the same cycle, the MDATA bit decides the pin.
- R8: Writing a 1 to FORCE (0x03) bit k applies channel k's pin action (the mask/data load for k = 0) at once and leaves every flag unchanged.
- R9: Writing 1 to a bit of FLAG1 or FLAG2 (0x09) clears that bit. Writing 0 leaves the bit unchanged.
- R10: irq_cmp[k] is FLAG1 bit k AND MASK1 (0x08) bit k. irq_cap[j] is FLAG1 bit 5+j AND MASK1 bit 5+j. irq_ovf is FLAG2 bit 0 AND MASK2 (0x0A) bit 0.
- R11: EDGE (0x0B) bits [2j+1:2j] select the edge for capture input j: 00 none, 01 rising, 10 falling, 11 both. On that edge, CAPj (high byte 0x20+2j, low 0x21+2j) stores the counter value of that cycle and FLAG1 bit 5+j becomes 1.
- R12: With CTRL bit 2 set, channel 4 captures instead of comparing. An edge on cap_pin[3], chosen by EDGE bits [7:6], loads CMP4 with the counter value and sets FLAG1 bit 4. In this mode, FORCE bit 4 and channel 4's own compare match do not change pin 4.
- R13: When the counter wraps from FFFF to 0000, FLAG2 bit 0 becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe, used for the counter byte save |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| cap_pin | input | NUM_IC+1 | Capture inputs; the top bit feeds the switchable channel |
| oc_pin | output | NUM_OC | Compare output pins |
| irq_cmp | output | NUM_OC | Compare channel requests |
| irq_cap | output | NUM_IC | Dedicated capture requests |
| irq_ovf | output | 1 | Counter wrap request |

## Verification
The rules below give the cycle in which each result appears. A compare flag, a pin action and a wrap flag appear in the same cycle that the counter shows the new value. Forced actions and flag clears show one edge after the write. A capture holds the counter value of the cycle in which the pin first shows the edge.

The bench reads the counter coherently at a known cycle. From that value it places each compare or capture a known number of cycles ahead. It samples once in the cycle before the event, which must show no change, and once in the event cycle. Prescale checks span 64 clocks, so the count difference does not depend on the prescaler phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CNT_W = 16;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_CLEAR  = 2'b10,
      ACT_SET    = 2'b11
   } act_e;

   localparam int A_CNT_HI   = 'h00;
   localparam int A_CNT_LO   = 'h01;
   localparam int A_CTRL     = 'h02;
   localparam int A_FORCE    = 'h03;
   localparam int A_MMASK    = 'h04;
   localparam int A_MDATA    = 'h05;
   localparam int A_ACT      = 'h06;
   localparam int A_FLAG1    = 'h07;
   localparam int A_MASK1    = 'h08;
   localparam int A_FLAG2    = 'h09;
   localparam int A_MASK2    = 'h0A;
   localparam int A_EDGE     = 'h0B;
   localparam int A_CMP_BASE = 'h10;
   localparam int A_CAP_BASE = 'h20;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
   parameter int W     = 16,
   parameter int PRE_W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   sel_i,
   output logic         tick_o,
   output logic         ovf_o,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] cnt_nxt_o
);
   generate
      if (PRE_W < 4) begin : g_bad_pre
         $error("tmr_tick: PRE_W must be at least 4");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] pre_mask;
   logic [W-1:0]     cnt_q;

   always_comb begin
      case (sel_i)
         2'd0:    pre_mask = PRE_W'(0);
         2'd1:    pre_mask = PRE_W'(3);
         2'd2:    pre_mask = PRE_W'(7);
         default: pre_mask = PRE_W'(15);
      endcase
   end

   assign tick_o    = (pre_q & pre_mask) == pre_mask;
   assign cnt_nxt_o = cnt_q + 1'b1;
   assign ovf_o     = tick_o && (&cnt_q);
   assign cnt_o     = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
         if (tick_o) cnt_q <= cnt_nxt_o;
      end
   end

   // R13
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> (cnt_q == '0));

   // R2
   div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == 2'd0) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic [1:0] edge_i,
   output logic       evt_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_i;
   end

   assign evt_o = (edge_i[0] & pin_i & ~prev_q) | (edge_i[1] & ~pin_i & prev_q);
endmodule

// File: rtl/tmr_pin_ctl.sv
module tmr_pin_ctl import tmr_pkg::*; #(
   parameter int N = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   own_evt_i,
   input  logic [2*N-1:0] code_i,
   input  logic           master_evt_i,
   input  logic [N-1:0]   mask_i,
   input  logic [N-1:0]   data_i,
   output logic [N-1:0]   pin_o
);
   logic [N-1:0] pin_q;
   logic [N-1:0] nxt_v;

   function automatic logic apply_act(input logic cur, input logic [1:0] code, input logic ev);
      logic r;
      r = cur;
      if (ev) begin
         case (act_e'(code))
            ACT_TOGGLE: r = ~cur;
            ACT_CLEAR:  r = 1'b0;
            ACT_SET:    r = 1'b1;
            default:    r = cur;
         endcase
      end
      return r;
   endfunction

   generate
      for (genvar p = 0; p < N; p++) begin : g_pin
         assign nxt_v[p] = (master_evt_i && mask_i[p]) ? data_i[p]
                         : apply_act(pin_q[p], code_i[2*p +: 2], own_evt_i[p]);

         // R7
         master_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (master_evt_i && mask_i[p]) |=> (pin_q[p] == $past(data_i[p])));

         // R4
         no_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!master_evt_i && own_evt_i[p] && code_i[2*p +: 2] == 2'b00) |=> $stable(pin_q[p]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= nxt_v;
   end

   assign pin_o = pin_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core import tmr_pkg::*; #(
   parameter int NUM_OC = 5,
   parameter int NUM_IC = 3,
   parameter int ADDR_W = 6,
   parameter int PRE_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic [NUM_IC:0]   cap_pin,
   output logic [NUM_OC-1:0] oc_pin,
   output logic [NUM_OC-1:0] irq_cmp,
   output logic [NUM_IC-1:0] irq_cap,
   output logic              irq_ovf
);
   localparam int NCAP   = NUM_IC + 1;
   localparam int FLAG_W = NUM_OC + NUM_IC;
   localparam int ACT_W  = 2 * (NUM_OC - 1);
   localparam int EDGE_W = 2 * NCAP;
   localparam int SH     = NUM_OC - 1;

   generate
      if (NUM_OC < 2 || NUM_OC > 5) begin : g_bad_oc
         $error("tmr_core: NUM_OC must lie in 2..5");
      end
      if (NUM_IC < 1 || NUM_IC > 3) begin : g_bad_ic
         $error("tmr_core: NUM_IC must lie in 1..3");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("tmr_core: ADDR_W must be at least 6");
      end
   endgenerate

   logic [2:0]        ctrl_q;
   logic [NUM_OC-1:0] mmask_q, mdata_q;
   logic [ACT_W-1:0]  act_q;
   logic [FLAG_W-1:0] flag1_q, mask1_q, set1, clr1;
   logic              flag2_q, mask2_q;
   logic [EDGE_W-1:0] edge_q;
   logic [7:0]        lo_buf_q;
   logic              lo_vld_q;

   logic              tick, ovf;
   logic [CNT_W-1:0]  cnt, cnt_nxt;
   logic [NUM_OC-1:0] match, force_evt, own_evt;
   logic [2*NUM_OC-1:0] own_code;
   logic [NCAP-1:0]   cap_evt;
   logic [CNT_W-1:0]  cmp_val [NUM_OC];
   logic [CNT_W-1:0]  cap_val [NUM_IC];
   logic              share_cap, cap_load, master_evt;

   assign share_cap = ctrl_q[2];
   assign cap_load  = share_cap & cap_evt[NUM_IC];

   function automatic logic hit(input int a);
      return addr == ADDR_W'(a);
   endfunction

   tmr_tick #(.W(CNT_W), .PRE_W(PRE_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .sel_i(ctrl_q[1:0]), .tick_o(tick),
      .ovf_o(ovf), .cnt_o(cnt), .cnt_nxt_o(cnt_nxt)
   );

   generate
      for (genvar k = 0; k < NUM_OC; k++) begin : g_cmp
         localparam bit IS_SH = (k == SH);
         logic [CNT_W-1:0] val_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                                     val_q <= '0;
            else if (IS_SH && cap_load)                     val_q <= cnt;
            else if (wr_en && hit(A_CMP_BASE + 2*k))        val_q[15:8] <= wdata;
            else if (wr_en && hit(A_CMP_BASE + 2*k + 1))    val_q[7:0]  <= wdata;
         end
         assign cmp_val[k] = val_q;
         assign match[k]   = tick && (cnt_nxt == val_q) && !(IS_SH && share_cap);
      end

      for (genvar j = 0; j < NCAP; j++) begin : g_edge
         tmr_capture u_cap (
            .clk(clk), .rst_n(rst_n), .pin_i(cap_pin[j]),
            .edge_i(edge_q[2*j +: 2]), .evt_o(cap_evt[j])
         );
      end

      for (genvar j = 0; j < NUM_IC; j++) begin : g_cap
         logic [CNT_W-1:0] val_q;
         always_ff @(posedge clk) begin
            if (!rst_n)          val_q <= '0;
            else if (cap_evt[j]) val_q <= cnt;
         end
         assign cap_val[j] = val_q;
      end

      assign own_code[1:0] = 2'b00;
      for (genvar p = 1; p < NUM_OC; p++) begin : g_code
         assign own_code[2*p +: 2] = act_q[2*(p-1) +: 2];
      end
   endgenerate

   assign force_evt  = (wr_en && hit(A_FORCE)) ? wdata[NUM_OC-1:0] : '0;
   assign master_evt = match[0] | force_evt[0];

   always_comb begin
      own_evt    = match | force_evt;
      own_evt[0] = 1'b0;
      if (share_cap) own_evt[SH] = 1'b0;
   end

   always_comb begin
      set1 = '0;
      set1[NUM_OC-1:0]      = match;
      set1[SH]              = match[SH] | cap_load;
      set1[FLAG_W-1:NUM_OC] = cap_evt[NUM_IC-1:0];
      clr1 = (wr_en && hit(A_FLAG1)) ? wdata[FLAG_W-1:0] : '0;
   end

   tmr_pin_ctl #(.N(NUM_OC)) u_pins (
      .clk(clk), .rst_n(rst_n), .own_evt_i(own_evt), .code_i(own_code),
      .master_evt_i(master_evt), .mask_i(mmask_q), .data_i(mdata_q), .pin_o(oc_pin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         mmask_q  <= '0;
         mdata_q  <= '0;
         act_q    <= '0;
         mask1_q  <= '0;
         mask2_q  <= 1'b0;
         edge_q   <= '0;
         flag1_q  <= '0;
         flag2_q  <= 1'b0;
         lo_buf_q <= '0;
         lo_vld_q <= 1'b0;
      end else begin
         if (wr_en) begin
            if (hit(A_CTRL))  ctrl_q  <= wdata[2:0];
            if (hit(A_MMASK)) mmask_q <= wdata[NUM_OC-1:0];
            if (hit(A_MDATA)) mdata_q <= wdata[NUM_OC-1:0];
            if (hit(A_ACT))   act_q   <= wdata[ACT_W-1:0];
            if (hit(A_MASK1)) mask1_q <= wdata[FLAG_W-1:0];
            if (hit(A_MASK2)) mask2_q <= wdata[0];
            if (hit(A_EDGE))  edge_q  <= wdata[EDGE_W-1:0];
         end
         flag1_q  <= (flag1_q & ~clr1) | set1;
         flag2_q  <= (flag2_q & ~(wr_en && hit(A_FLAG2) && wdata[0])) | ovf;
         lo_vld_q <= rd_en && hit(A_CNT_HI);
         if (rd_en && hit(A_CNT_HI)) lo_buf_q <= cnt[7:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (hit(A_CNT_HI))      rdata = cnt[15:8];
      else if (hit(A_CNT_LO)) rdata = lo_vld_q ? lo_buf_q : cnt[7:0];
      else if (hit(A_CTRL))   rdata = 8'(ctrl_q);
      else if (hit(A_MMASK))  rdata = 8'(mmask_q);
      else if (hit(A_MDATA))  rdata = 8'(mdata_q);
      else if (hit(A_ACT))    rdata = 8'(act_q);
      else if (hit(A_FLAG1))  rdata = 8'(flag1_q);
      else if (hit(A_MASK1))  rdata = 8'(mask1_q);
      else if (hit(A_FLAG2))  rdata = 8'(flag2_q);
      else if (hit(A_MASK2))  rdata = 8'(mask2_q);
      else if (hit(A_EDGE))   rdata = 8'(edge_q);
      for (int k = 0; k < NUM_OC; k++) begin
         if (hit(A_CMP_BASE + 2*k))     rdata = cmp_val[k][15:8];
         if (hit(A_CMP_BASE + 2*k + 1)) rdata = cmp_val[k][7:0];
      end
      for (int j = 0; j < NUM_IC; j++) begin
         if (hit(A_CAP_BASE + 2*j))     rdata = cap_val[j][15:8];
         if (hit(A_CAP_BASE + 2*j + 1)) rdata = cap_val[j][7:0];
      end
   end

   assign irq_cmp = flag1_q[NUM_OC-1:0] & mask1_q[NUM_OC-1:0];
   assign irq_cap = flag1_q[FLAG_W-1:NUM_OC] & mask1_q[FLAG_W-1:NUM_OC];
   assign irq_ovf = flag2_q & mask2_q;

   // R9
   flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_FLAG1) && wdata[1] && !set1[1]) |=> !flag1_q[1]);

   // R12
   shared_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (share_cap && force_evt[SH] && !(master_evt && mmask_q[SH]))
      |=> (oc_pin[SH] == $past(oc_pin[SH])));
endmodule

// File: tb/tmr_core_tb.sv
module tmr_core_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] R_CHI = 6'h00, R_CLO = 6'h01, R_CTRL = 6'h02, R_FORCE = 6'h03,
      R_MMASK = 6'h04, R_MDATA = 6'h05, R_ACT = 6'h06, R_FLAG1 = 6'h07, R_MASK1 = 6'h08,
      R_FLAG2 = 6'h09, R_MASK2 = 6'h0A, R_EDGE = 6'h0B;

   // {channel[2:0], code[1:0], pin after first force, pin after second force}
   localparam logic [6:0] ACT_VEC [10] = '{
      {3'd1, 2'b11, 1'b1, 1'b1}, {3'd1, 2'b01, 1'b0, 1'b1}, {3'd1, 2'b10, 1'b0, 1'b0},
      {3'd1, 2'b00, 1'b0, 1'b0}, {3'd2, 2'b01, 1'b1, 1'b0}, {3'd2, 2'b11, 1'b1, 1'b1},
      {3'd3, 2'b10, 1'b0, 1'b0}, {3'd3, 2'b01, 1'b1, 1'b0}, {3'd4, 2'b11, 1'b1, 1'b1},
      {3'd4, 2'b00, 1'b1, 1'b1}};

   logic       clk = 1'b0;
   logic       rst_n;
   logic [5:0] addr;
   logic       wr_en, rd_en;
   logic [7:0] wdata, rdata;
   logic [3:0] cap_pin;
   logic [4:0] oc_pin, irq_cmp;
   logic [2:0] irq_cap;
   logic       irq_ovf;

   int checks = 0;
   int fails  = 0;

   tmr_core u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .cap_pin(cap_pin), .oc_pin(oc_pin),
      .irq_cmp(irq_cmp), .irq_cap(irq_cap), .irq_ovf(irq_ovf)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      addr = a; rd_en = 1'b1; wr_en = 1'b0;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_cnt(output logic [15:0] v);
      logic [7:0] h, l;
      rd(R_CHI, h);
      rd(R_CLO, l);
      v = {h, l};
   endtask

   task automatic rd_cnt_low(output logic [15:0] v);
      do rd_cnt(v); while (v[7:0] >= 8'd128);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [7:0]  d, l1, l2;
      logic [15:0] v, v2;
      logic [4:0]  exp_pin;
      logic [7:0]  act_sh;
      rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0; cap_pin = '0;
      exp_pin = '0; act_sh = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pins", oc_pin, 0);
      check("R1 irqs", {irq_cmp, irq_cap, irq_ovf}, 0);
      addr = R_CHI; #1 check("R1 cnt hi", rdata, 0);
      addr = R_FLAG1; #1 check("R1 flag1", rdata, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R3 coherent read, then live reads
      rd(R_CHI, d); rd(R_CLO, l1); rd(R_CLO, l2);
      check("R3 live low after buffered", l2, 8'(l1 + 8'd2));
      rd(R_CLO, l2);
      check("R3 second live low", l2, 8'(l1 + 8'd3));

      // R2 prescale periods over 64 clocks
      for (int s = 0; s < 4; s++) begin
         int div;
         div = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 16;
         wr(R_CTRL, 8'(s));
         rd_cnt(v);
         repeat (62) @(negedge clk);
         rd_cnt(v2);
         check($sformatf("R2 prescale sel=%0d", s), 16'(v2 - v), 16'(64 / div));
      end
      wr(R_CTRL, 8'h00);

      // R4 / R8 action table via the force register
      for (int i = 0; i < 10; i++) begin
         int ch;
         ch = int'(ACT_VEC[i][6:4]);
         act_sh[2*(ch-1) +: 2] = ACT_VEC[i][3:2];
         wr(R_ACT, act_sh);
         wr(R_FORCE, 8'(1 << ch));
         exp_pin[ch] = ACT_VEC[i][1];
         check($sformatf("R4 vec %0d first", i), oc_pin, exp_pin);
         wr(R_FORCE, 8'(1 << ch));
         exp_pin[ch] = ACT_VEC[i][0];
         check($sformatf("R4 vec %0d second", i), oc_pin, exp_pin);
      end
      rd(R_FLAG1, d);
      check("R8 force sets no flag", d, 0);

      // R5 / R10 compare match on channel 2 (toggle)
      act_sh[3:2] = 2'b01;
      wr(R_ACT, act_sh);
      wr(R_MASK1, 8'h04);
      rd_cnt_low(v);
      v2 = v + 16'd40;
      wr(8'h14, v2[15:8]); wr(8'h15, v2[7:0]);
      repeat (35) @(negedge clk);
      check("R5 pin before match", oc_pin, exp_pin);
      rd(R_FLAG1, d);
      check("R5 flag before match", d, 0);
      exp_pin[2] = ~exp_pin[2];
      check("R5 pin at match", oc_pin, exp_pin);
      check("R10 irq_cmp raised", irq_cmp, 5'h04);
      rd(R_FLAG1, d);
      check("R5 flag at match", d, 8'h04);
      wr(R_FLAG1, 8'h04);
      check("R10 irq_cmp dropped", irq_cmp, 0);

      // R6 / R7 master and channel 2 (set) on the same value
      act_sh[3:2] = 2'b11;
      wr(R_ACT, act_sh);
      wr(R_MMASK, 8'h14); wr(R_MDATA, 8'h00);
      rd_cnt_low(v);
      v2 = v + 16'd40;
      wr(8'h10, v2[15:8]); wr(8'h11, v2[7:0]);
      wr(8'h14, v2[15:8]); wr(8'h15, v2[7:0]);
      repeat (33) @(negedge clk);
      check("R6 pins before match", oc_pin, exp_pin);
      @(negedge clk);
      exp_pin[2] = 1'b0; exp_pin[4] = 1'b0;
      check("R7 master data wins on pin2, R6 pin4 loaded", oc_pin, exp_pin);
      rd(R_FLAG1, d);
      check("R6 flags at match", d, 8'h05);

      // R9 write-one clear
      wr(R_FLAG1, 8'h00);
      rd(R_FLAG1, d);
      check("R9 zero write keeps flags", d, 8'h05);
      wr(R_FLAG1, 8'h04);
      rd(R_FLAG1, d);
      check("R9 one write clears bit", d, 8'h01);
      wr(R_FLAG1, 8'hFF);

      // R8 master force
      wr(R_MDATA, 8'h1F); wr(R_MMASK, 8'h03);
      wr(R_FORCE, 8'h01);
      exp_pin[1:0] = 2'b11;
      check("R8 master force pins", oc_pin, exp_pin);
      rd(R_FLAG1, d);
      check("R8 master force no flag", d, 0);

      // R11 capture: ch0 rising, ch1 falling
      wr(R_EDGE, 8'h09);
      wr(R_MASK1, 8'h20);
      rd_cnt(v);
      cap_pin[0] = 1'b1;
      @(negedge clk);
      rd(8'h20, d); rd(8'h21, l1);
      check("R11 capture rising value", {d, l1}, 16'(v + 16'd2));
      check("R10 irq_cap raised", irq_cap, 3'b001);
      cap_pin[1] = 1'b1;
      repeat (2) @(negedge clk);
      rd(R_FLAG1, d);
      check("R11 rising ignored on falling channel", d, 8'h20);
      rd_cnt(v);
      cap_pin[1] = 1'b0;
      @(negedge clk);
      rd(8'h22, d); rd(8'h23, l1);
      check("R11 capture falling value", {d, l1}, 16'(v + 16'd2));
      rd(R_FLAG1, d);
      check("R11 falling flag", d, 8'h60);
      wr(R_FLAG1, 8'hFF);

      // R12 shared channel in capture mode
      wr(R_CTRL, 8'h04);
      wr(R_EDGE, 8'hC9);
      act_sh[7:6] = 2'b01;
      wr(R_ACT, act_sh);
      wr(R_MMASK, 8'h00);
      rd_cnt(v);
      cap_pin[3] = 1'b1;
      @(negedge clk);
      rd(8'h18, d); rd(8'h19, l1);
      check("R12 shared capture value", {d, l1}, 16'(v + 16'd2));
      rd(R_FLAG1, d);
      check("R12 shared flag", d, 8'h10);
      wr(R_FORCE, 8'h10);
      check("R12 force ignored in capture mode", oc_pin, exp_pin);
      wr(R_CTRL, 8'h00);
      wr(R_FORCE, 8'h10);
      exp_pin[4] = ~exp_pin[4];
      check("R12 force acts in compare mode", oc_pin, exp_pin);

      // R13 wrap flag
      wr(R_MASK2, 8'h01);
      wr(R_FLAG2, 8'h01);
      rd_cnt(v);
      repeat (65536 - int'(v) - 3) @(negedge clk);
      rd(R_FLAG2, d);
      check("R13 flag before wrap", d, 0);
      check("R10 irq_ovf after wrap", irq_ovf, 1);
      rd(R_FLAG2, d);
      check("R13 flag at wrap", d, 1);
      rd(R_CHI, d);
      check("R13 counter restarted", d, 0);

      summary();
      $finish;
   end
endmodule